// File: doc/BRIEF.md
# Security-Aware Interrupt Priority Byte Array

This block holds one 8-bit priority value for each of 32 private interrupts and serves a simple request/response register port over them. The port addresses the array by byte offset 0x00 to 0x1F. A request is either a single-byte access, which touches one interrupt, or a 32-bit word access, which touches four neighbouring interrupts at once. The response comes back one cycle after the request. It carries read data and an error flag.

Each request also carries a secure attribute. The block takes two further inputs: a 32-bit group vector, with one bit per interrupt, and a global flag that turns the security model off. When security is on and a request is non-secure, the block applies a restricted view. Interrupts whose group bit is 0 are invisible: they read as zero and ignore writes. Interrupts whose group bit is 1 are translated. A read returns the stored value shifted left by one. A write stores the written byte shifted right by one, with the top bit forced to one. Secure requests, and every request while security is off, see the stored bytes unchanged.

Top module: `prio_byte_array`

## Requirements
- R1: After reset every stored priority is 0x00, and rsp_valid is 0.
- R2: A request with req_valid=1 produces rsp_valid=1 in the next cycle, and only then. The response to a write, or to an erroring request, has rsp_rdata=0.
- R3: A request is an error when req_offset is 0x20 or above, or when req_word=1 and req_offset[1:0] is not 0. An error gives rsp_err=1 and rsp_rdata=0, and it leaves every stored priority unchanged.
- R4: When req_secure=1, or when sec_disable=1, a read returns the stored byte and a write stores the written byte, whatever the group vector holds.
- R5: The restricted view applies when req_secure=0 and sec_disable=0. Under it, an interrupt whose grp_vec bit is 0 reads as 0x00, and writes to it leave its stored value unchanged.
- R6: Under the restricted view, a read of an interrupt whose grp_vec bit is 1 returns (stored << 1) truncated to 8 bits.
- R7: Under the restricted view, a write to an interrupt whose grp_vec bit is 1 stores 0x80 | (written byte >> 1).
- R8: A word access (req_word=1) at offset n covers interrupts n to n+3. Interrupt n+k occupies bits [8k+7:8k] of rsp_rdata and of req_wdata, and the rules of R4 to R7 are applied to each byte on its own.
- R9: A byte access (req_word=0) at offset n touches only interrupt n. It writes req_wdata[7:0], and it reads into rsp_rdata[7:0] with rsp_rdata[31:8]=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 32-bit word access, 0 = single byte |
| req_secure | input | 1 | 1 = secure request |
| req_offset | input | 8 | Byte offset of the access |
| req_wdata | input | 32 | Write data; byte accesses use bits [7:0] |
| grp_vec | input | 32 | Group bit per interrupt; 1 = visible to the restricted view |
| sec_disable | input | 1 | 1 = security model off, all requests see raw bytes |
| rsp_valid | output | 1 | Response present, one cycle after a request |
| rsp_err | output | 1 | Request was rejected (range or alignment) |
| rsp_rdata | output | 32 | Read data |

## Verification
The assertions take for granted that grp_vec, sec_disable and all the request fields are meaningful in the cycle when req_valid is high. The block samples them at that point, and nothing ties a response to values those inputs held at any other time. The stimulus changes the group vector and the security controls only on the falling clock edge that also launches a request. Every expected result is therefore worked out from the values held in that same request cycle. Offsets are drawn a little past the 0x1F boundary, and word accesses are mostly aligned, so the error paths are exercised without crowding out the legal ones.

// File: rtl/prio_byte_array.sv
module prio_byte_array #(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 8,
  parameter int LANES   = 4,
  parameter int OFFS_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic                      req_word,
  input  logic                      req_secure,
  input  logic [OFFS_W-1:0]         req_offset,
  input  logic [LANES*PRIO_W-1:0]   req_wdata,
  input  logic [NUM_IRQ-1:0]        grp_vec,
  input  logic                      sec_disable,
  output logic                      rsp_valid,
  output logic                      rsp_err,
  output logic [LANES*PRIO_W-1:0]   rsp_rdata
);
  localparam int DATA_W    = LANES * PRIO_W;
  localparam int IDX_W     = $clog2(NUM_IRQ);
  localparam int LANE_BITS = $clog2(LANES);
  localparam logic [OFFS_W-1:0] OFFS_LIMIT = OFFS_W'(NUM_IRQ);

  logic [PRIO_W-1:0] prio [NUM_IRQ];

  logic restricted, bad, acc_ok;
  logic [IDX_W-1:0] base;

  assign restricted = !req_secure && !sec_disable;
  assign bad = (req_offset >= OFFS_LIMIT) ||
               (req_word && (req_offset[LANE_BITS-1:0] != '0));
  assign acc_ok = req_valid && !bad;
  assign base = req_offset[IDX_W-1:0];

  logic [IDX_W-1:0]  lane_idx  [LANES];
  logic              lane_we   [LANES];
  logic [PRIO_W-1:0] lane_wval [LANES];
  logic [DATA_W-1:0] rd_word;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic              on, vis;
    logic [PRIO_W-1:0] wbyte, stored;
    assign lane_idx[l] = base + IDX_W'(l);
    assign on     = (l == 0) || req_word;
    assign vis    = !restricted || grp_vec[lane_idx[l]];
    assign wbyte  = req_wdata[l*PRIO_W +: PRIO_W];
    assign stored = prio[lane_idx[l]];
    assign lane_we[l]   = acc_ok && req_write && on && vis;
    assign lane_wval[l] = restricted ? {1'b1, wbyte[PRIO_W-1:1]} : wbyte;
    assign rd_word[l*PRIO_W +: PRIO_W] =
      !(on && vis)  ? '0 :
      restricted    ? {stored[PRIO_W-2:0], 1'b0} : stored;
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    logic              we;
    logic [PRIO_W-1:0] wd;
    always_comb begin
      we = 1'b0;
      wd = '0;
      for (int l = 0; l < LANES; l++) begin
        if (lane_we[l] && lane_idx[l] == IDX_W'(i)) begin
          we = 1'b1;
          wd = lane_wval[l];
        end
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  prio[i] <= '0;
      else if (we) prio[i] <= wd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && bad;
      rsp_rdata <= (acc_ok && !req_write) ? rd_word : '0;
    end
  end
endmodule

// File: rtl/prio_byte_array_chk.sv
module prio_byte_array_chk #(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 8,
  parameter int LANES   = 4,
  parameter int OFFS_W  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_write,
  input logic                    req_word,
  input logic                    req_secure,
  input logic [OFFS_W-1:0]       req_offset,
  input logic [LANES*PRIO_W-1:0] req_wdata,
  input logic [NUM_IRQ-1:0]      grp_vec,
  input logic                    sec_disable,
  input logic                    rsp_valid,
  input logic                    rsp_err,
  input logic [LANES*PRIO_W-1:0] rsp_rdata
);
  localparam int IDX_W = $clog2(NUM_IRQ);
  localparam logic [OFFS_W-1:0] OFFS_LIMIT = OFFS_W'(NUM_IRQ);

  logic ns_byte_rd;
  assign ns_byte_rd = req_valid && !req_write && !req_word && !req_secure &&
                      !sec_disable && (req_offset < OFFS_LIMIT);

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2
  AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (rsp_rdata == '0)); // R2
  AST_RANGE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_offset >= OFFS_LIMIT) |=> rsp_err); // R3
  AST_ALIGN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_word && req_offset[1:0] != 2'b00) |=> rsp_err); // R3
  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == '0)); // R3
  AST_HIDDEN_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_byte_rd && !grp_vec[req_offset[IDX_W-1:0]]) |=> (rsp_rdata == '0)); // R5
  AST_NS_READ_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    ns_byte_rd |=> !rsp_rdata[0]); // R6
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_word) |=> (rsp_rdata[LANES*PRIO_W-1:PRIO_W] == '0)); // R9
endmodule

bind prio_byte_array prio_byte_array_chk #(
  .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .LANES(LANES), .OFFS_W(OFFS_W)
) u_chk (.*);

// File: tb/tb_prio_byte_array.sv
module tb_prio_byte_array;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0, req_secure = 1'b0;
  logic [7:0]  req_offset = '0;
  logic [31:0] req_wdata = '0, grp_vec = '0;
  logic        sec_disable = 1'b0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;

  prio_byte_array dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  bit [7:0]  ref_prio [32];
  bit [31:0] tb_grp;
  bit        nx_valid, nx_err, ex_valid, ex_err;
  bit [31:0] nx_data, ex_data;
  string     nx_tag = "R1", ex_tag = "R1";
  int        n_vec = 0, n_bad = 0;
  bit        armed = 0, done = 0;

  always @(posedge clk) begin
    ex_valid <= nx_valid;
    ex_err   <= nx_err;
    ex_data  <= nx_data;
    ex_tag   <= nx_tag;
  end

  always @(negedge clk) if (armed && !done) begin
    n_vec++;
    if (rsp_valid !== ex_valid || rsp_err !== ex_err || rsp_rdata !== ex_data) begin
      n_bad++;
      $display("FAIL %s: got v=%0b e=%0b d=%08h expected v=%0b e=%0b d=%08h",
               ex_tag, rsp_valid, rsp_err, rsp_rdata, ex_valid, ex_err, ex_data);
    end
  end

  function automatic bit [7:0] view(int irq, bit sec, bit dis);
    if (!sec && !dis) begin
      if (!tb_grp[irq]) return 8'h00;
      return {ref_prio[irq][6:0], 1'b0};
    end
    return ref_prio[irq];
  endfunction

  task automatic issue(bit wr, bit word, bit sec, bit dis, int off, bit [31:0] wd, string tag);
    int  n;
    bit  err;
    bit [7:0] b;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_word = word; req_secure = sec;
    sec_disable = dis; req_offset = 8'(off); req_wdata = wd; grp_vec = tb_grp;
    err = (off >= 32) || (word && (off % 4) != 0);
    nx_valid = 1; nx_err = err; nx_data = '0; nx_tag = tag;
    if (!err) begin
      n = word ? 4 : 1;
      for (int k = 0; k < n; k++) begin
        b = wd[8*k +: 8];
        if (wr) begin
          if (sec || dis) ref_prio[off+k] = b;
          else if (tb_grp[off+k]) ref_prio[off+k] = 8'h80 | (b >> 1);
        end else begin
          nx_data[8*k +: 8] = view(off+k, sec, dis);
        end
      end
    end
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0; req_write = 0;
    nx_valid = 0; nx_err = 0; nx_data = '0; nx_tag = "R2";
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL R2: watchdog expired, got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    tb_grp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1; armed = 1;
    idle(); idle();
    // R1: all zero after reset
    for (int a = 0; a < 32; a += 4) issue(0, 1, 1, 0, a, 0, "R1");
    // R4: secure raw word writes and readback
    for (int a = 0; a < 32; a += 4) issue(1, 1, 1, 0, a, 32'h10203040 + a * 32'h01010101, "R4");
    for (int a = 0; a < 32; a += 4) issue(0, 1, 1, 0, a, 0, "R8");
    // R9: single byte write touches only that interrupt
    issue(1, 0, 1, 0, 5, 32'hFFFF_FFA5, "R9");
    issue(0, 1, 1, 0, 4, 0, "R9");
    issue(0, 0, 1, 0, 5, 0, "R9");
    // restricted view with mixed groups
    tb_grp = 32'h0000_FF0F;
    issue(0, 0, 0, 0, 4, 0, "R5");
    issue(0, 0, 0, 0, 2, 0, "R6");
    issue(0, 1, 0, 0, 0, 0, "R8");
    issue(0, 1, 0, 0, 8, 0, "R8");
    issue(1, 0, 0, 0, 20, 32'h0000_00FF, "R5");
    issue(0, 0, 1, 0, 20, 0, "R5");
    issue(1, 0, 0, 0, 1, 32'h0000_0046, "R7");
    issue(0, 0, 1, 0, 1, 0, "R7");
    issue(1, 1, 0, 0, 0, 32'h1122_3344, "R8");
    issue(0, 1, 1, 0, 0, 0, "R8");
    issue(1, 1, 0, 0, 4, 32'hAABB_CCDD, "R8");
    issue(0, 1, 1, 0, 4, 0, "R8");
    // R4: security disabled, non-secure sees raw bytes
    issue(1, 0, 0, 1, 20, 32'h0000_0033, "R4");
    issue(0, 0, 0, 1, 20, 0, "R4");
    issue(0, 1, 0, 1, 0, 0, "R4");
    // R3: errors do nothing
    issue(0, 1, 1, 0, 2, 0, "R3");
    issue(1, 1, 1, 0, 6, 32'hDEAD_BEEF, "R3");
    issue(1, 0, 1, 0, 32, 32'h77, "R3");
    issue(1, 1, 1, 0, 64, 32'hCAFE_F00D, "R3");
    issue(0, 1, 1, 0, 4, 0, "R3");
    issue(0, 0, 1, 0, 31, 0, "R9");
    idle();
    // mixed random traffic
    for (int i = 0; i < 500; i++) begin
      bit wr, word, sec, dis;
      int off;
      if ($urandom_range(0, 9) == 0) tb_grp = $urandom;
      wr   = 1'($urandom_range(0, 1));
      word = 1'($urandom_range(0, 1));
      sec  = 1'($urandom_range(0, 1));
      dis  = ($urandom_range(0, 4) == 0);
      off  = $urandom_range(0, 39);
      if (word && $urandom_range(0, 3) != 0) off = off & ~3;
      if (off >= 32 || (word && off % 4 != 0)) issue(wr, word, sec, dis, off, $urandom, "R3");
      else if (sec || dis) issue(wr, word, sec, dis, off, $urandom, "R4");
      else if (word) issue(wr, word, sec, dis, off, $urandom, "R8");
      else if (wr) issue(wr, word, sec, dis, off, $urandom, "R7");
      else issue(wr, word, sec, dis, off, $urandom, "R6");
      if ($urandom_range(0, 7) == 0) idle();
    end
    for (int a = 0; a < 32; a += 4) issue(0, 1, 1, 0, a, 0, "R8");
    idle(); idle();
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule